// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a number of pins that is a multiple of 32. Software reads and writes 32-bit words through a simple port with a byte address. Each 32-pin bank has one word of each register kind. Every pin has an input, an output value and an output enable. A single interrupt line is raised while any latched edge is pending.

Every input passes through a two-flop synchronizer. The synchronized value is what software reads back, and it feeds the edge detectors. Output values change only through write-one set and write-one clear words, so software never needs a read-modify-write sequence to drive a pin. Each pin has rising and falling enables. When an enabled edge is seen, the pin's status bit latches and stays set until software writes a one to it. Each pin also has a 2-bit alternate-function field that is stored and read back. Sixteen pins share each word of that region.

Register kinds, with index k: 0 level (read-only), 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. With NREG = NPINS/32, the word of kind k for bank b sits at byte address k*NREG*4 + b*4. Pin p uses bit p%32 of its bank word. The alternate-function region starts at 7*NREG*4 and holds 2*NREG words. The field of pin p is in word p/16 of that region, at bits (p%16)*2+1 : (p%16)*2. There is no control state machine: all registers are flat and update in the same cycle as the write.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register reads zero, and pin_oe, pin_out and irq are all low.
- R2: A read of the level word of bank b returns the pins of that bank, delayed by the two-flop synchronizer. Read data appears in the cycle after rd_en.
- R3: A direction bit of 1 drives the pin's pin_oe high (output), and 0 makes the pin an input. The word reads back as written.
- R4: Writing 1 to a bit of the set word drives that pin's pin_out high. Bits written as 0 keep their value.
- R5: Writing 1 to a bit of the clear word drives that pin's pin_out low. Bits written as 0 keep their value.
- R6: A rising edge on a pin whose rising enable is 1 sets its status bit. The bit is visible on the third clock edge after the input changes.
- R7: A falling edge on a pin whose falling enable is 1 sets its status bit. An edge of the opposite polarity leaves the bit clear.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing all ones clears the whole bank.
- R9: If an enabled edge is detected in the same cycle as a write-one clear of that bit, the bit stays set.
- R10: irq is high exactly while at least one status bit is set in any bank.
- R11: Each alternate-function word holds 2-bit fields for 16 pins. Pin p uses word 7*NREG+p/16 and bits (p%16)*2+1 : (p%16)*2. Writing one word leaves the other words unchanged.
- R12: Reads at or beyond byte address (9*NREG)*4 return zero. Writes to the level word change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; rdata updates on the next edge |
| addr | input | ADDR_W | Word-aligned byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pin input levels (asynchronous) |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables (1 = drive) |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench builds the controller with NPINS = 64 and ADDR_W = 12, which gives two banks. With two banks, the address arithmetic for the second bank is exercised, and a write aimed at one bank can be checked against the other. The alternate-function region then spans four words, so a field in the second word can be checked while its neighbour stays zero. The bench also reads an address above the 72-byte map, and it places an edge and its clear in the same cycle to check the race rule.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    typedef enum logic [2:0] {
        K_LEVEL = 3'd0,
        K_DIR   = 3'd1,
        K_SET   = 3'd2,
        K_CLR   = 3'd3,
        K_RISE  = 3'd4,
        K_FALL  = 3'd5,
        K_STAT  = 3'd6,
        K_ALT   = 3'd7
    } regkind_e;

    localparam int unsigned BANK_W = 32;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lvl_i,
    input  logic [BANK_W-1:0] wdata,
    input  logic              we_dir,
    input  logic              we_set,
    input  logic              we_clr,
    input  logic              we_rise,
    input  logic              we_fall,
    input  logic              we_stat,
    output logic [BANK_W-1:0] dir_o,
    output logic [BANK_W-1:0] out_o,
    output logic [BANK_W-1:0] rise_o,
    output logic [BANK_W-1:0] fall_o,
    output logic [BANK_W-1:0] stat_o
);
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] hit;
    logic [BANK_W-1:0] clr_mask;

    // Edge hits from the synchronized level against its previous sample.
    always_comb begin
        hit      = (lvl_i & ~prev_q & rise_o) | (~lvl_i & prev_q & fall_o);
        clr_mask = we_stat ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            dir_o  <= '0;
            out_o  <= '0;
            rise_o <= '0;
            fall_o <= '0;
            stat_o <= '0;
        end else begin
            prev_q <= lvl_i;
            if (we_dir)  dir_o  <= wdata;
            if (we_rise) rise_o <= wdata;
            if (we_fall) fall_o <= wdata;
            if (we_set)
                out_o <= out_o | wdata;
            else if (we_clr)
                out_o <= out_o & ~wdata;
            // A new hit wins over a clear of the same bit.
            stat_o <= (stat_o & ~clr_mask) | hit;
        end
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS  = 64,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int unsigned NREG       = NPINS / BANK_W;
    localparam int unsigned NALT       = 2 * NREG;
    localparam int unsigned MAIN_WORDS = 7 * NREG;
    localparam int unsigned NWORDS     = MAIN_WORDS + NALT;
    localparam int unsigned BW         = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned AW         = $clog2(NALT);

    logic [NPINS-1:0] lvl_sync;

    logic [NREG-1:0][BANK_W-1:0] dir_w, out_w, rise_w, fall_w, stat_w;
    logic [NREG-1:0] we_dir, we_set, we_clr, we_rise, we_fall, we_stat;
    logic [31:0] alt_q [NALT];

    int unsigned widx;
    logic        in_main;
    logic        in_alt;
    regkind_e    kind;
    logic [BW-1:0] bsel;
    logic [AW-1:0] asel;
    logic [31:0]   rd_mux;
    logic          unused_lsb;

    assign unused_lsb = ^addr[1:0];

    pinbank_sync #(.W(NPINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl_sync)
    );

    // Address decode: kind and bank for the main region, word for the alt region.
    always_comb begin
        widx    = 32'(addr[ADDR_W-1:2]);
        in_main = (widx < MAIN_WORDS);
        in_alt  = !in_main && (widx < NWORDS);
        kind    = K_LEVEL;
        bsel    = '0;
        asel    = '0;
        if (in_main) begin
            kind = regkind_e'(3'(widx / NREG));
            bsel = BW'(widx % NREG);
        end else if (in_alt) begin
            kind = K_ALT;
            asel = AW'(widx - MAIN_WORDS);
        end
    end

    for (genvar b = 0; b < NREG; b++) begin : g_bank
        logic sel;
        assign sel        = wr_en && in_main && (bsel == BW'(b));
        assign we_dir[b]  = sel && (kind == K_DIR);
        assign we_set[b]  = sel && (kind == K_SET);
        assign we_clr[b]  = sel && (kind == K_CLR);
        assign we_rise[b] = sel && (kind == K_RISE);
        assign we_fall[b] = sel && (kind == K_FALL);
        assign we_stat[b] = sel && (kind == K_STAT);

        pinbank_bank i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (lvl_sync[b*BANK_W +: BANK_W]),
            .wdata   (wdata),
            .we_dir  (we_dir[b]),
            .we_set  (we_set[b]),
            .we_clr  (we_clr[b]),
            .we_rise (we_rise[b]),
            .we_fall (we_fall[b]),
            .we_stat (we_stat[b]),
            .dir_o   (dir_w[b]),
            .out_o   (out_w[b]),
            .rise_o  (rise_w[b]),
            .fall_o  (fall_w[b]),
            .stat_o  (stat_w[b])
        );

        assign pin_oe[b*BANK_W +: BANK_W]  = dir_w[b];
        assign pin_out[b*BANK_W +: BANK_W] = out_w[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NALT); i++) alt_q[i] <= '0;
        end else if (wr_en && in_alt) begin
            alt_q[asel] <= wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (in_main) begin
            unique case (kind)
                K_LEVEL:       rd_mux = lvl_sync[bsel*BANK_W +: BANK_W];
                K_DIR:         rd_mux = dir_w[bsel];
                K_SET, K_CLR:  rd_mux = out_w[bsel];
                K_RISE:        rd_mux = rise_w[bsel];
                K_FALL:        rd_mux = fall_w[bsel];
                K_STAT:        rd_mux = stat_w[bsel];
                K_ALT:         rd_mux = '0;
            endcase
        end else if (in_alt) begin
            rd_mux = alt_q[asel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign irq = |stat_w;
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int unsigned NPINS  = 64,
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq
);
    localparam int unsigned NREG     = NPINS / 32;
    localparam logic [ADDR_W-1:0] A_LVL0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(1 * NREG * 4);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(2 * NREG * 4);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(3 * NREG * 4);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(9 * NREG * 4);

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR0) |=> (pin_oe[31:0] == $past(wdata)));

    // R4
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SET0) |=> ((pin_out[31:0] & $past(wdata)) == $past(wdata)));

    // R5
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CLR0) |=> ((pin_out[31:0] & $past(wdata)) == 32'd0));

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));

    // R12
    lvl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LVL0) |=> ($stable(pin_oe) && $stable(pin_out)));

    // R12
    far_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= A_END) |=> (rdata == 32'd0));
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/test_pinbank_ctrl.sv
`timescale 1ns/1ps
module test_pinbank_ctrl;
    localparam int NPINS  = 64;
    localparam int ADDR_W = 12;
    localparam int NREG   = NPINS / 32;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              wr_en = 0;
    logic              rd_en = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NPINS-1:0]  pin_in = '0;
    logic [NPINS-1:0]  pin_out;
    logic [NPINS-1:0]  pin_oe;
    logic              irq;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pinbank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_pinbank_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    function automatic int ra(input int kind, input int bank);
        return kind * NREG * 4 + bank * 4;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a[ADDR_W-1:0]; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = a[ADDR_W-1:0];
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32], 0);
        chk("R1 pin_out", pin_out[31:0] | pin_out[63:32], 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rd(ra(1, 1), v); chk("R1 dir bank1", v, 0);
        rd(ra(6, 0), v); chk("R1 status bank0", v, 0);
        rd(ra(7, 0) + 4, v); chk("R1 alt word1", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk); pin_in = {32'hDEAD_BEEF, 32'h1234_5678};
        settle();
        rd(ra(0, 0), v); chk("R2 level bank0", v, 32'h1234_5678);
        rd(ra(0, 1), v); chk("R2 level bank1", v, 32'hDEAD_BEEF);
        @(negedge clk); pin_in = {32'h0F0F_0000, 32'h8000_0001};
        settle();
        rd(ra(0, 0), v); chk("R2 level bank0 b", v, 32'h8000_0001);
        rd(ra(0, 1), v); chk("R2 level bank1 b", v, 32'h0F0F_0000);
        @(negedge clk); pin_in = '0;
        settle();
        rd(ra(6, 0), v); chk("R2 no status w/o enables", v, 0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(ra(1, 1), 32'hF0F0_0F0F);
        chk("R3 pin_oe bank1", pin_oe[63:32], 32'hF0F0_0F0F);
        chk("R3 pin_oe bank0 untouched", pin_oe[31:0], 0);
        rd(ra(1, 1), v); chk("R3 dir readback", v, 32'hF0F0_0F0F);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(ra(2, 0), 32'h0000_00FF);
        chk("R4 set", pin_out[31:0], 32'h0000_00FF);
        wr(ra(2, 0), 32'h0000_0100);
        chk("R4 zero bits keep", pin_out[31:0], 32'h0000_01FF);
        wr(ra(3, 0), 32'h0000_000F);
        chk("R5 clear", pin_out[31:0], 32'h0000_01F0);
        wr(ra(2, 1), 32'h8000_0000);
        chk("R4 set bank1", pin_out[63:32], 32'h8000_0000);
        rd(ra(3, 0), v); chk("R5 out readback", v, 32'h0000_01F0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(ra(4, 0), 32'h0000_0008);
        @(negedge clk); pin_in[3] = 1;
        @(posedge clk); @(posedge clk); #1;
        chk("R6 not yet after two edges", {31'd0, irq}, 0);
        @(posedge clk); #1;
        chk("R6/R10 irq on third edge", {31'd0, irq}, 1);
        rd(ra(6, 0), v); chk("R6 status bank0", v, 32'h0000_0008);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(ra(6, 0), 32'h0000_0000);
        rd(ra(6, 0), v); chk("R8 zero write keeps", v, 32'h0000_0008);
        wr(ra(6, 0), 32'h0000_0008);
        rd(ra(6, 0), v); chk("R8 w1c clears", v, 0);
        chk("R10 irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(ra(5, 1), 32'h0000_0004);
        @(negedge clk); pin_in[34] = 1;
        settle();
        rd(ra(6, 1), v); chk("R7 rise ignored by fall enable", v, 0);
        @(negedge clk); pin_in[34] = 0;
        settle();
        rd(ra(6, 1), v); chk("R7 fall latched", v, 32'h0000_0004);
        chk("R10 irq from bank1", {31'd0, irq}, 1);
        wr(ra(6, 1), 32'hFFFF_FFFF);
        rd(ra(6, 1), v); chk("R8 all ones clears bank", v, 0);
        chk("R10 irq low after bank clear", {31'd0, irq}, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(ra(4, 0), 32'h0000_0020);
        wr(ra(5, 0), 32'h0000_0020);
        @(negedge clk); pin_in[5] = 1;
        settle();
        rd(ra(6, 0), v); chk("R9 first edge", v, 32'h0000_0020);
        @(negedge clk); pin_in[5] = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1; addr = ra(6, 0); wdata = 32'h0000_0020;
        @(negedge clk); wr_en = 0;
        rd(ra(6, 0), v); chk("R9 edge beats clear", v, 32'h0000_0020);
        wr(ra(6, 0), 32'h0000_0020);
        rd(ra(6, 0), v); chk("R9 later clear works", v, 0);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        wr(ra(7, 0) + 4, 32'h0000_0200);
        rd(ra(7, 0) + 4, v); chk("R11 alt pin20 field", (v >> 8) & 3, 2);
        rd(ra(7, 0), v); chk("R11 alt word0 untouched", v, 0);
        rd(ra(7, 0) + 12, v); chk("R11 alt word3 untouched", v, 0);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        logic [NPINS-1:0] oe0, out0;
        oe0 = pin_oe; out0 = pin_out;
        wr(ra(0, 0), 32'hFFFF_FFFF);
        chk("R12 level write oe", pin_oe[31:0], oe0[31:0]);
        chk("R12 level write out", pin_out[31:0], out0[31:0]);
        rd(ra(0, 0), v); chk("R12 level unchanged", v, 32'h0000_0008);
        rd(9 * NREG * 4, v); chk("R12 first past end", v, 0);
        rd(12'h100, v); chk("R12 far address", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_level();
        t_dir();
        t_setclr();
        t_rise();
        t_w1c();
        t_fall();
        t_race();
        t_alt();
        t_misc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule